// File: doc/BRIEF.md
# Control Endpoint Register Interlock

This block keeps the two registers that steer the control endpoint of a low-speed USB device controller: an endpoint mode register and a byte-count register. Two agents update them. The serial interface engine posts transaction events and new field values. A CPU reads and writes the registers through an I/O port. The block decides which update lands, and it shields state that the engine has just produced from being overwritten by firmware that has not yet seen it.

Two interlocks do this. The first is a setup flag in bit 7 of the mode register. It is forced on from the moment a setup data phase begins until the device starts its ACK. After that it cannot be cleared until the CPU has read the mode register. While the flag is on, CPU writes into the two eight-byte packet buffer windows are suppressed. The second interlock is a lock on mode bits 6:0. It is raised whenever the engine changes any of those bits at the end of an acknowledged transaction. While it is raised, CPU writes to those bits are dropped without notice. Firmware releases the lock by reading the register, and must read back after a write to confirm that the write took effect.

Top module: `usb_ep0_interlock`

## Requirements
- R1: One cycle after `sie_setup_data` pulses, `mode_reg[7]` (setup flag) is 1, and it stays 1 on every cycle up to and including the cycle after `sie_ack_start`.
- R2: From a `sie_setup_data` pulse onward, CPU writes cannot change `mode_reg[7]`. This holds until the CPU reads the mode register (`cpu_sel`=0) on a cycle after `sie_ack_start` has closed the window. After that read, a CPU write sets bit 7 to `cpu_wdata[7]` on the next cycle.
- R3: On `sie_xfer_ack`, the next cycle shows mode bits 6:5 = `sie_dir_flags`, bit 4 (acknowledge) = 1 and bits 3:0 = `sie_mode_code`. The lock is raised only if this changed at least one of bits 6:0.
- R4: While the lock is raised, CPU writes leave mode bits 6:0 unchanged. A CPU read of the mode register releases the lock. When unlocked, a CPU write to the mode register updates bits 6:0 one cycle later.
- R5: When the engine and the CPU write the same register in the same cycle, the engine's value is stored. For the mode register, the lock is also raised if the engine's value changed bits 6:0.
- R6: `buf_we` equals `cpu_buf_wr`, except that it is 0 while `mode_reg[7]` is 1 and `cpu_buf_addr` lies in 0xE0–0xE7 or 0xF8–0xFF.
- R7: The count register holds the toggle in bit 7 (0 = DATA0, 1 = DATA1), data-valid in bit 6, zeros in bits 5:4 and the byte count in bits 3:0. A count above 8 is stored as 8. It is written from `cpu_wdata` (with `cpu_sel`=1) or from `sie_cnt_in` (with `sie_cnt_we`).
- R8: `cpu_rdata` shows the mode register when `cpu_sel`=0 and the count register when `cpu_sel`=1, in the same cycle.
- R9: Reset clears both registers, the setup flag, the window, the hold and the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sie_setup_data | input | 1 | Pulse: data phase of a setup transaction begins |
| sie_ack_start | input | 1 | Pulse: device begins sending its ACK |
| sie_xfer_ack | input | 1 | Pulse: transaction finished with ACK; loads mode bits 6:0 |
| sie_dir_flags | input | 2 | Engine value for mode bits 6:5 |
| sie_mode_code | input | 4 | Engine value for mode bits 3:0 |
| sie_cnt_we | input | 1 | Engine write strobe for the count register |
| sie_cnt_in | input | 8 | Engine value for the count register |
| cpu_sel | input | 1 | Register select: 0 mode, 1 count |
| cpu_rd | input | 1 | CPU register read strobe |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU readback of the selected register |
| cpu_buf_wr | input | 1 | CPU packet buffer write request |
| cpu_buf_addr | input | 8 | CPU packet buffer address |
| buf_we | output | 1 | Guarded packet buffer write enable |
| mode_reg | output | 8 | Mode register contents |
| cnt_reg | output | 8 | Count register contents |

## Verification
The hardest state to reach is a setup flag that is still held after its window has closed. This needs a setup data pulse, then an ACK start, then write attempts before any mode read. The engine's end-of-transfer update also raises the bit-field lock in the middle of this sequence. The stimulus walks that exact sequence. It shows that a read inside the window does not release the hold, and that the single read afterwards releases both the hold and the lock at once. The buffer guard is swept over all 256 addresses with the flag both on and off.

// File: rtl/usb_ep0_interlock.sv
module usb_ep0_interlock #(
  parameter int AW = 8,
  parameter logic [AW-1:0] GUARD_A = 8'hE0,
  parameter logic [AW-1:0] GUARD_B = 8'hF8,
  parameter int SPAN_LOG2 = 3,
  parameter int MAX_COUNT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sie_setup_data,
  input  logic          sie_ack_start,
  input  logic          sie_xfer_ack,
  input  logic [1:0]    sie_dir_flags,
  input  logic [3:0]    sie_mode_code,
  input  logic          sie_cnt_we,
  input  logic [7:0]    sie_cnt_in,
  input  logic          cpu_sel,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic [7:0]    cpu_wdata,
  output logic [7:0]    cpu_rdata,
  input  logic          cpu_buf_wr,
  input  logic [AW-1:0] cpu_buf_addr,
  output logic          buf_we,
  output logic [7:0]    mode_reg,
  output logic [7:0]    cnt_reg
);
  localparam int TAG_W = AW - SPAN_LOG2;

  logic       setup_q, win_q, hold_q, lock_q;
  logic [6:0] low_q, sie_low;
  logic [7:0] cnt_q;
  logic       mode_rd, mode_wr, cnt_wr, in_guard;

  function automatic logic [7:0] fmt_cnt(input logic [7:0] d);
    logic [3:0] c;
    c = (d[3:0] > 4'(MAX_COUNT)) ? 4'(MAX_COUNT) : d[3:0];
    return {d[7:6], 2'b00, c};
  endfunction

  assign mode_rd = cpu_rd && !cpu_sel;
  assign mode_wr = cpu_wr && !cpu_sel;
  assign cnt_wr  = cpu_wr && cpu_sel;
  assign sie_low = {sie_dir_flags, 1'b1, sie_mode_code};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q   <= 1'b0;
      hold_q  <= 1'b0;
      setup_q <= 1'b0;
    end else begin
      if (sie_setup_data)     win_q <= 1'b1;
      else if (sie_ack_start) win_q <= 1'b0;

      if (sie_setup_data)               hold_q <= 1'b1;
      else if (mode_rd && !win_q)       hold_q <= 1'b0;

      if (sie_setup_data || win_q)      setup_q <= 1'b1;
      else if (mode_wr && !hold_q)      setup_q <= cpu_wdata[7];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_q  <= '0;
      lock_q <= 1'b0;
    end else if (sie_xfer_ack) begin
      low_q <= sie_low;
      if (sie_low != low_q) lock_q <= 1'b1;
      else if (mode_rd)     lock_q <= 1'b0;
    end else begin
      if (mode_wr && !lock_q) low_q <= cpu_wdata[6:0];
      if (mode_rd)            lock_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (sie_cnt_we) cnt_q <= fmt_cnt(sie_cnt_in);
    else if (cnt_wr)     cnt_q <= fmt_cnt(cpu_wdata);
  end

  assign in_guard  = (cpu_buf_addr[AW-1:SPAN_LOG2] == GUARD_A[AW-1:SPAN_LOG2]) ||
                     (cpu_buf_addr[AW-1:SPAN_LOG2] == GUARD_B[AW-1:SPAN_LOG2]);
  assign buf_we    = cpu_buf_wr && !(setup_q && in_guard);
  assign mode_reg  = {setup_q, low_q};
  assign cnt_reg   = cnt_q;
  assign cpu_rdata = cpu_sel ? cnt_q : mode_reg;

  AST_SETUP_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    (sie_setup_data || win_q) |=> mode_reg[7]); // R1
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !(mode_rd && !win_q)) |=> mode_reg[7]); // R2
  AST_ACK_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    sie_xfer_ack |=> mode_reg[4]); // R3
  AST_LOCK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !sie_xfer_ack) |=> $stable(mode_reg[6:0])); // R4
  AST_BUF_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_we && mode_reg[7]) |-> !in_guard); // R6
  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_reg[3:0] <= 4'(MAX_COUNT)) && (cnt_reg[5:4] == 2'b00)); // R7
  logic unused_tag;
  assign unused_tag = ^TAG_W;
endmodule

// File: tb/tb_usb_ep0_interlock.sv
module tb_usb_ep0_interlock;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sie_setup_data = 0, sie_ack_start = 0, sie_xfer_ack = 0, sie_cnt_we = 0;
  logic [1:0] sie_dir_flags = 0;
  logic [3:0] sie_mode_code = 0;
  logic [7:0] sie_cnt_in = 0, cpu_wdata = 0, cpu_buf_addr = 0;
  logic cpu_sel = 0, cpu_rd = 0, cpu_wr = 0, cpu_buf_wr = 0;
  logic [7:0] cpu_rdata, mode_reg, cnt_reg;
  logic buf_we;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  usb_ep0_interlock dut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic sel, input logic [7:0] d);
    cpu_sel = sel; cpu_wdata = d; cpu_wr = 1;
    @(negedge clk); cpu_wr = 0;
  endtask

  task automatic cpu_read(input logic sel, output logic [7:0] d);
    cpu_sel = sel; cpu_rd = 1; #1 d = cpu_rdata;
    @(negedge clk); cpu_rd = 0;
  endtask

  task automatic sie_done(input logic [1:0] f, input logic [3:0] m);
    sie_dir_flags = f; sie_mode_code = m; sie_xfer_ack = 1;
    @(negedge clk); sie_xfer_ack = 0;
  endtask

  task automatic buf_sweep(input logic flag_on, input string req);
    for (int a = 0; a < 256; a++) begin
      logic g;
      cpu_buf_addr = 8'(a); cpu_buf_wr = 1; #1;
      g = (a >= 8'hE0 && a <= 8'hE7) || (a >= 8'hF8);
      chk(req, {7'd0, buf_we}, {7'd0, !(flag_on && g)});
      cpu_buf_wr = 0; #1;
      chk(req, {7'd0, buf_we}, 8'h00);
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    chk("R9 mode", mode_reg, 8'h00);
    chk("R9 cnt", cnt_reg, 8'h00);
    rst_n = 1;
    @(negedge clk);

    // R7 / R8 sweep of every count write value
    for (int v = 0; v < 256; v++) begin
      logic [7:0] e;
      e = {v[7:6], 2'b00, (v[3:0] > 8) ? 4'd8 : v[3:0]};
      cpu_write(1, 8'(v));
      chk("R7 count", cnt_reg, e);
      cpu_read(1, rd);
      chk("R8 count read", rd, e);
    end

    // unlocked mode writes, bit 7 writable with no hold
    cpu_write(0, 8'h25); chk("R4 unlocked write", mode_reg, 8'h25);
    cpu_write(0, 8'h8A); chk("R2 bit7 free", mode_reg, 8'h8A);
    cpu_write(0, 8'h0A); chk("R2 bit7 clear", mode_reg, 8'h0A);
    cpu_read(0, rd);     chk("R8 mode read", rd, 8'h0A);

    // engine update raises lock
    sie_done(2'b10, 4'h3);
    chk("R3 sie load", mode_reg, 8'h53);
    cpu_write(0, 8'h07); chk("R4 locked drop", mode_reg, 8'h53);
    cpu_write(0, 8'h7F); chk("R4 locked drop2", mode_reg, 8'h53);
    cpu_read(0, rd);     chk("R8 mode read", rd, 8'h53);
    cpu_write(0, 8'h07); chk("R4 unlock by read", mode_reg, 8'h07);

    // engine update with no change: no lock
    cpu_write(0, 8'h53); chk("R4 unlocked write", mode_reg, 8'h53);
    sie_done(2'b10, 4'h3);
    chk("R3 same value", mode_reg, 8'h53);
    cpu_write(0, 8'h02); chk("R3 no lock when unchanged", mode_reg, 8'h02);

    // same-cycle collisions
    sie_dir_flags = 2'b01; sie_mode_code = 4'h1; sie_xfer_ack = 1;
    cpu_sel = 0; cpu_wdata = 8'h0F; cpu_wr = 1;
    @(negedge clk); sie_xfer_ack = 0; cpu_wr = 0;
    chk("R5 sie wins mode", mode_reg, 8'h31);
    cpu_write(0, 8'h0F); chk("R5 lock set on collision", mode_reg, 8'h31);
    cpu_read(0, rd);
    sie_cnt_in = 8'hC5; sie_cnt_we = 1;
    cpu_sel = 1; cpu_wdata = 8'h03; cpu_wr = 1;
    @(negedge clk); sie_cnt_we = 0; cpu_wr = 0;
    chk("R5 sie wins count", cnt_reg, 8'hC5);
    sie_cnt_in = 8'h7F; sie_cnt_we = 1;
    @(negedge clk); sie_cnt_we = 0;
    chk("R7 sie clamp", cnt_reg, 8'h48);

    // setup window and hold
    buf_sweep(0, "R6 flag off");
    sie_setup_data = 1; @(negedge clk); sie_setup_data = 0;
    chk("R1 flag set", mode_reg, 8'hB1);
    repeat (3) @(negedge clk);
    chk("R1 flag stays", mode_reg, 8'hB1);
    cpu_write(0, 8'h00); chk("R2 window write", mode_reg, 8'h80);
    cpu_read(0, rd);     chk("R8 window read", rd, 8'h80);
    cpu_write(0, 8'h00); chk("R2 read in window no release", mode_reg, 8'h80);
    buf_sweep(1, "R6 flag on");
    sie_ack_start = 1; @(negedge clk); sie_ack_start = 0;
    chk("R1 flag at ack", mode_reg, 8'h80);
    cpu_write(0, 8'h00); chk("R2 held after window", mode_reg, 8'h80);
    sie_done(2'b00, 4'h0);
    chk("R3 ack after setup", mode_reg, 8'h90);
    cpu_write(0, 8'h05); chk("R4 locked after setup", mode_reg, 8'h90);
    cpu_read(0, rd);     chk("R8 read releases", rd, 8'h90);
    cpu_write(0, 8'h05); chk("R2 release by read", mode_reg, 8'h05);
    buf_sweep(0, "R6 flag off again");

    // reset mid-operation
    sie_setup_data = 1; @(negedge clk); sie_setup_data = 0;
    sie_done(2'b11, 4'hF);
    rst_n = 0; @(negedge clk);
    chk("R9 mode reset", mode_reg, 8'h00);
    chk("R9 cnt reset", cnt_reg, 8'h00);
    rst_n = 1; @(negedge clk);
    cpu_write(0, 8'h06); chk("R9 lock and hold cleared", mode_reg, 8'h06);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule